// File: doc/BRIEF.md
# Burst Address Sequencer

This block holds the word address presented to a synchronous memory array and steps it through a four-word burst. A load command captures an external address and opens a burst. Each following advance command moves the two lowest address bits to the next position of the burst. The bits above them keep the value that was loaded.

A static mode input picks the order of the burst. In wrapping-increment order the low bits count up modulo four from the start value. In interleaved order the low bits are the start bits XORed with a running count of 0 to 3. The same command input carries both load and advance. A load taken while the device is not selected closes the open burst. A suspend input freezes every register for as long as it is held.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `arr_addr_o` is 0 and `burst_act_o` is 0.
- R2: A selected load (`suspend_i`=0, `adv_nload_i`=0, device selected) makes `arr_addr_o` equal `ext_addr_i` from the next cycle and sets `burst_act_o` to 1.
- R3: With `ilv_mode_i`=0, each advance in an active burst adds 1 modulo 4 to `arr_addr_o[1:0]`. For example, a start of 2 gives 2,3,0,1.
- R4: With `ilv_mode_i`=1, the k-th word of the burst (k = 0..3) has `arr_addr_o[1:0]` = start[1:0] XOR k. For example, a start of 1 gives 1,0,3,2.
- R5: Advances never change `arr_addr_o[ADDR_W-1:2]`.
- R6: Advancing after the fourth word wraps around, so the fifth word equals the first and the sequence repeats.
- R7: An advance (`adv_nload_i`=1) while `burst_act_o` is 0 leaves `arr_addr_o` unchanged.
- R8: A load while the device is deselected clears `burst_act_o` and leaves `arr_addr_o` unchanged. Later advances do not move the address.
- R9: While `suspend_i`=1, `arr_addr_o` and `burst_act_o` hold their values, whatever the other inputs do.
- R10: `ext_addr_i` has no effect during an advance.
- R11: The device is selected only when `sel_n_a_i`=0, `sel_n_b_i`=0 and `sel_p_i`=1. If any one of the three is false, a load acts as a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| suspend_i | input | 1 | 1 freezes all state at this edge |
| adv_nload_i | input | 1 | 0 = load or deselect, 1 = advance |
| sel_n_a_i | input | 1 | Select, active low |
| sel_n_b_i | input | 1 | Select, active low |
| sel_p_i | input | 1 | Select, active high |
| ilv_mode_i | input | 1 | Static burst order: 0 wrapping increment, 1 interleaved |
| ext_addr_i | input | ADDR_W | External start address |
| arr_addr_o | output | ADDR_W | Current array word address |
| burst_act_o | output | 1 | A burst is open |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a suspend and a command. The bench raises `suspend_i` in the same cycle that it offers a selected load with a new address. It does the same again with a deselecting load while a burst is open. In both cases the outputs must match their values from before that edge.

The second pair is a burst termination in the middle of a sequence. The bench closes a burst partway through by dropping one select input during a load. It then issues advances and expects the address to stay frozen at the last word.

// File: rtl/bag_pkg.sv
package bag_pkg;
    typedef enum logic [2:0] {
        CMD_HOLD,
        CMD_LOAD,
        CMD_STOP,
        CMD_STEP,
        CMD_IDLE
    } bag_cmd_e;
endpackage

// File: rtl/bag_cmd_decode.sv
module bag_cmd_decode
    import bag_pkg::*;
(
    input  logic     suspend_i,
    input  logic     adv_nload_i,
    input  logic     sel_n_a_i,
    input  logic     sel_n_b_i,
    input  logic     sel_p_i,
    input  logic     act_i,
    output bag_cmd_e cmd_o
);
    logic selected;

    assign selected = !sel_n_a_i && !sel_n_b_i && sel_p_i;

    always_comb begin
        if (suspend_i) begin
            cmd_o = CMD_HOLD;
        end else if (!adv_nload_i) begin
            cmd_o = selected ? CMD_LOAD : CMD_STOP;
        end else begin
            cmd_o = act_i ? CMD_STEP : CMD_IDLE;
        end
    end
endmodule

// File: rtl/bag_seq_offset.sv
module bag_seq_offset #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             ilv_i,
    output logic [CNT_W-1:0] low_o
);
    logic [CNT_W-1:0] lin_low;
    logic [CNT_W-1:0] ilv_low;

    assign lin_low = start_i + count_i;
    assign ilv_low = start_i ^ count_i;
    assign low_o   = ilv_i ? ilv_low : lin_low;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              suspend_i,
    input  logic              adv_nload_i,
    input  logic              sel_n_a_i,
    input  logic              sel_n_b_i,
    input  logic              sel_p_i,
    input  logic              ilv_mode_i,
    input  logic [ADDR_W-1:0] ext_addr_i,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic              burst_act_o
);
    localparam int CNT_W = $clog2(BURST_LEN);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  cnt;
        logic              act;
    } bag_state_t;

    bag_state_t st_d, st_q;
    bag_cmd_e   cmd;
    logic [CNT_W-1:0] low_bits;

    bag_cmd_decode u_dec (
        .suspend_i  (suspend_i),
        .adv_nload_i(adv_nload_i),
        .sel_n_a_i  (sel_n_a_i),
        .sel_n_b_i  (sel_n_b_i),
        .sel_p_i    (sel_p_i),
        .act_i      (st_q.act),
        .cmd_o      (cmd)
    );

    bag_seq_offset #(.CNT_W(CNT_W)) u_seq (
        .start_i(st_q.base[CNT_W-1:0]),
        .count_i(st_q.cnt),
        .ilv_i  (ilv_mode_i),
        .low_o  (low_bits)
    );

    always_comb begin
        st_d = st_q;
        case (cmd)
            CMD_LOAD: begin
                st_d.base = ext_addr_i;
                st_d.cnt  = '0;
                st_d.act  = 1'b1;
            end
            CMD_STOP: st_d.act = 1'b0;
            CMD_STEP: st_d.cnt = st_q.cnt + 1'b1;
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign arr_addr_o  = {st_q.base[ADDR_W-1:CNT_W], low_bits};
    assign burst_act_o = st_q.act;
endmodule

// File: rtl/bag_chk.sv
module bag_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              suspend_i,
    input logic              adv_nload_i,
    input logic              sel_n_a_i,
    input logic              sel_n_b_i,
    input logic              sel_p_i,
    input logic              ilv_mode_i,
    input logic [ADDR_W-1:0] ext_addr_i,
    input logic [ADDR_W-1:0] arr_addr_o,
    input logic              burst_act_o
);
    logic sel_ok;
    assign sel_ok = !sel_n_a_i && !sel_n_b_i && sel_p_i;

    // R9
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_i |=> ($stable(arr_addr_o) && $stable(burst_act_o)));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend_i && !adv_nload_i && sel_ok)
        |=> (arr_addr_o == $past(ext_addr_i) && burst_act_o));

    // R8
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend_i && !adv_nload_i && !sel_ok)
        |=> (!burst_act_o && $stable(arr_addr_o)));

    // R7
    idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend_i && adv_nload_i && !burst_act_o)
        |=> ($stable(arr_addr_o) && !burst_act_o));

    // R5
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend_i && adv_nload_i) |=> $stable(arr_addr_o[ADDR_W-1:2]));

    // R3
    lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend_i && adv_nload_i && burst_act_o && !ilv_mode_i && $stable(ilv_mode_i))
        |=> (arr_addr_o[1:0] == $past(arr_addr_o[1:0]) + 2'd1));
endmodule

bind burst_addr_gen bag_chk #(.ADDR_W(ADDR_W)) u_bag_chk (.*);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
    localparam int AW = 17;

    typedef struct {
        logic [AW-1:0] addr;
        logic          act;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          suspend_i = 1'b0;
    logic          adv_nload_i = 1'b1;
    logic          sel_n_a_i = 1'b0;
    logic          sel_n_b_i = 1'b0;
    logic          sel_p_i = 1'b1;
    logic          ilv_mode_i = 1'b0;
    logic [AW-1:0] ext_addr_i = '0;
    logic [AW-1:0] arr_addr_o;
    logic          burst_act_o;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut (.*);

    task automatic judge(input logic [AW-1:0] ea, input logic eb, input string tag);
        checks++;
        if (arr_addr_o !== ea || burst_act_o !== eb) begin
            errors++;
            $display("FAIL %s: addr=%h act=%b expected addr=%h act=%b",
                     tag, arr_addr_o, burst_act_o, ea, eb);
        end
    endtask

    task automatic cyc(input logic sus, input logic adv, input logic na, input logic nb,
                       input logic p, input logic [AW-1:0] ext,
                       input logic [AW-1:0] ea, input logic eb, input string tag);
        exp_t e;
        @(negedge clk);
        suspend_i = sus; adv_nload_i = adv;
        sel_n_a_i = na; sel_n_b_i = nb; sel_p_i = p; ext_addr_i = ext;
        e.addr = ea; e.act = eb; e.tag = tag;
        sb_q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                judge(e.addr, e.act, e.tag);
            end
        end
    end

    initial begin : driver
        #12;
        judge('0, 1'b0, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R7: advance with nothing loaded
        cyc(0, 1, 0, 0, 1, 17'h0_1234, 17'h0, 0, "R7 idle advance");
        // Linear burst from start 2 (R2, R3, R5, R10, R6)
        ilv_mode_i = 1'b0;
        cyc(0, 0, 0, 0, 1, 17'h1_ABC2, 17'h1_ABC2, 1, "R2 load");
        cyc(0, 1, 0, 0, 1, 17'h0_0F0F, 17'h1_ABC3, 1, "R3 R10 step1");
        cyc(0, 1, 0, 0, 1, 17'h1_FFFF, 17'h1_ABC0, 1, "R3 R5 step2");
        cyc(0, 1, 0, 0, 1, 17'h0_0000, 17'h1_ABC1, 1, "R3 step3");
        cyc(0, 1, 0, 0, 1, 17'h0_0000, 17'h1_ABC2, 1, "R6 wrap");
        // R9: suspend together with a selected load
        cyc(1, 0, 0, 0, 1, 17'h0_7777, 17'h1_ABC2, 1, "R9 suspend over load");
        // Interleaved burst from start 1 (R4)
        @(negedge clk); ilv_mode_i = 1'b1;
        cyc(0, 0, 0, 0, 1, 17'h0_5551, 17'h0_5551, 1, "R4 load");
        cyc(0, 1, 0, 0, 1, 17'h0_0000, 17'h0_5550, 1, "R4 step1");
        cyc(0, 1, 0, 0, 1, 17'h0_0000, 17'h0_5553, 1, "R4 step2");
        // R9: suspend together with a deselect mid burst
        cyc(1, 0, 0, 0, 0, 17'h0_0000, 17'h0_5553, 1, "R9 suspend over stop");
        cyc(0, 1, 0, 0, 1, 17'h0_0000, 17'h0_5552, 1, "R4 step3");
        cyc(0, 1, 0, 0, 1, 17'h0_0000, 17'h0_5551, 1, "R6 R4 wrap");
        // Deselect loads (R8, R11)
        cyc(0, 0, 0, 0, 0, 17'h1_1111, 17'h0_5551, 0, "R8 R11 stop by sel_p");
        cyc(0, 1, 0, 0, 1, 17'h1_1111, 17'h0_5551, 0, "R8 advance after stop");
        cyc(0, 0, 0, 0, 1, 17'h0_0003, 17'h0_0003, 1, "R4 load start3");
        cyc(0, 1, 0, 0, 1, 17'h0_0000, 17'h0_0002, 1, "R4 start3 step1");
        cyc(0, 0, 1, 0, 1, 17'h1_2340, 17'h0_0002, 0, "R11 stop by sel_n_a");
        cyc(0, 0, 0, 0, 1, 17'h0_0003, 17'h0_0003, 1, "R2 reload");
        cyc(0, 0, 0, 1, 1, 17'h1_2340, 17'h0_0003, 0, "R11 stop by sel_n_b");
        // Linear from start 0
        @(negedge clk); ilv_mode_i = 1'b0;
        cyc(0, 0, 0, 0, 1, 17'h1_0000, 17'h1_0000, 1, "R2 load start0");
        cyc(0, 1, 0, 0, 1, 17'h0_0000, 17'h1_0001, 1, "R3 step1");
        cyc(0, 1, 0, 0, 1, 17'h0_0000, 17'h1_0002, 1, "R3 step2");
        cyc(0, 1, 0, 0, 1, 17'h0_0000, 17'h1_0003, 1, "R3 step3");
        cyc(1, 1, 0, 0, 1, 17'h0_0000, 17'h1_0003, 1, "R9 suspend over step");
        @(negedge clk); adv_nload_i = 1'b1;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule